// File: doc/BRIEF.md
# Delayed-Branch Resolution Unit

This unit decides where control flow goes next for a 32-bit RISC core in which most control transfers have a single delay slot. For each issued instruction it receives the instruction word, the PC, the two source register values and the condition-code bit. It returns the next PC, whether the transfer is taken, and whether the instruction after it (the delay slot) executes before the jump. It also returns the return-address write for call forms and the register write made by the counting-loop instruction. Instructions that are not control transfers fall through to PC + 4.

Two bits of state live inside the unit. The first is a loop-condition flag. The counting-loop instruction branches on the value this flag held before the instruction, adds its two operands, and stores a fresh flag for the next loop instruction. The second is a bus-lock output, which the escape instruction sets and clears around atomic read-modify-write sequences. The fetch pipeline and the register file sit outside the unit.

Top module: `xfer_resolve`

## Requirements
- R1: Field layout: opcode is instr[31:26], the second source register field is instr[25:21], the first source register field is instr[15:11]. Opcode 0x1A (jump) and opcode 0x1B (call) are always taken, with a delay slot, to PC + 4 + 4*sext(instr[25:0]). Call also writes r1 with PC + 8 (link_we_o, link_data_o).
- R2: Opcodes 0x1C and 0x1D are taken when cc_i = 1. Opcodes 0x1E and 0x1F are taken when cc_i = 0. The target is PC + 4 + 4*sext(instr[25:0]). Only the odd forms (0x1D, 0x1F) raise delay_slot_o when taken.
- R3: Opcodes 0x14 to 0x17 compare rs2_i with an operand. On an odd opcode the operand is the zero-extended 5-bit instr[15:11]; on an even opcode it is rs1_i. Opcodes 0x14 and 0x15 are taken on inequality; 0x16 and 0x17 are taken on equality. The target is PC + 4 + 4*sext({instr[20:16], instr[10:0]}). These never raise delay_slot_o.
- R4: Opcode 0x10 is always taken, with a delay slot, to rs1_i.
- R5: Opcode 0x13 with instr[4:0] = 2 is always taken, with a delay slot, to rs1_i, and it writes r1 with PC + 8.
- R6: Opcode 0x2D is taken, with a delay slot, exactly when the stored loop flag is 1. The target uses the split offset of R3. The instruction always writes rs1_i + rs2_i (mod 2^32) to the register named by instr[25:21].
- R7: Each opcode 0x2D instruction replaces the loop flag. When rs1_i is negative, the new flag is 1 if the 32-bit sum is non-negative as a signed value. Otherwise the new flag is the carry out of the unsigned 32-bit add.
- R8: Opcode 0x13 with instr[4:0] = 1 sets bus_lock_o from the next cycle. Sub-op 7 clears it. Sub-op 4 changes nothing and does not branch.
- R9: Opcode 0x13 with any other sub-op raises illegal_o, does not branch, and leaves bus_lock_o unchanged.
- R10: After reset the loop flag is 0 and bus_lock_o is 0, so the first opcode 0x2D instruction falls through.
- R11: When valid_i = 0, or the opcode is not a control transfer, or the transfer is not taken: next_pc_o = PC + 4, taken_o = 0 and delay_slot_o = 0. With valid_i = 0 there are also no writes, and neither the loop flag nor the lock changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rs1_i | input | 32 | Value of the first source register |
| rs2_i | input | 32 | Value of the second source register |
| cc_i | input | 1 | Condition-code bit |
| next_pc_o | output | 32 | Address to fetch after this instruction (after its delay slot, if any) |
| taken_o | output | 1 | Transfer taken |
| delay_slot_o | output | 1 | Slot at PC + 4 executes before the jump |
| link_we_o | output | 1 | Write r1 |
| link_data_o | output | 32 | Return address for r1 |
| loop_we_o | output | 1 | Write the loop sum |
| loop_rd_o | output | 5 | Destination register of the loop sum |
| loop_sum_o | output | 32 | rs1_i + rs2_i |
| bus_lock_o | output | 1 | Bus lock held |
| illegal_o | output | 1 | Unknown escape sub-op |

## Verification
A wrong loop flag appears only at the next opcode 0x2D instruction. It shows up as a wrong taken_o and a wrong next_pc_o, however many other instructions come in between. Each flag test therefore follows a loop instruction with a second one as a probe. A wrong lock state is visible on bus_lock_o in the cycle after the escape instruction. All other errors are combinational and appear in the same cycle the instruction is presented.

// File: rtl/xfer_resolve.sv
module xfer_resolve #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic            cc_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic            taken_o,
  output logic            delay_slot_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_data_o,
  output logic            loop_we_o,
  output logic [4:0]      loop_rd_o,
  output logic [XLEN-1:0] loop_sum_o,
  output logic            bus_lock_o,
  output logic            illegal_o
);
  localparam logic [5:0] OP_BRI  = 6'h10;
  localparam logic [5:0] OP_ESC  = 6'h13;
  localparam logic [5:0] OP_JMP  = 6'h1A;
  localparam logic [5:0] OP_CALL = 6'h1B;
  localparam logic [5:0] OP_LOOP = 6'h2D;
  localparam logic [4:0] ESC_LOCK   = 5'd1;
  localparam logic [4:0] ESC_CALLI  = 5'd2;
  localparam logic [4:0] ESC_NOP    = 5'd4;
  localparam logic [4:0] ESC_UNLOCK = 5'd7;

  logic [5:0] op;
  logic [4:0] f_s1, sub;
  logic [15:0] split;
  logic [XLEN-1:0] seq_pc, off26, off16, cmp_a;
  logic [XLEN:0] sum_w;
  logic lcc_q, lcc_next, cmp_eq;

  assign op     = instr_i[31:26];
  assign f_s1   = instr_i[15:11];
  assign sub    = instr_i[4:0];
  assign split  = {instr_i[20:16], instr_i[10:0]};
  assign seq_pc = pc_i + XLEN'(4);
  assign off26  = XLEN'({{(XLEN-28){instr_i[25]}}, instr_i[25:0], 2'b00});
  assign off16  = XLEN'({{(XLEN-18){split[15]}}, split, 2'b00});
  assign cmp_a  = op[0] ? XLEN'(f_s1) : rs1_i;
  assign cmp_eq = (cmp_a == rs2_i);
  assign sum_w  = {1'b0, rs1_i} + {1'b0, rs2_i};
  assign lcc_next = rs1_i[XLEN-1] ? ~sum_w[XLEN-1] : sum_w[XLEN];

  logic tk, dly, lnk, lpw, lk_set, lk_clr, ill;
  logic [XLEN-1:0] tgt;

  always_comb begin
    tk = 1'b0; dly = 1'b0; lnk = 1'b0; lpw = 1'b0;
    lk_set = 1'b0; lk_clr = 1'b0; ill = 1'b0;
    tgt = seq_pc;
    unique case (op)
      OP_JMP, OP_CALL: begin
        tk = 1'b1; dly = 1'b1; tgt = seq_pc + off26; lnk = op[0];
      end
      6'h1C, 6'h1D, 6'h1E, 6'h1F: begin
        tk = op[1] ? ~cc_i : cc_i; dly = op[0]; tgt = seq_pc + off26;
      end
      6'h14, 6'h15, 6'h16, 6'h17: begin
        tk = op[1] ? cmp_eq : ~cmp_eq; tgt = seq_pc + off16;
      end
      OP_BRI: begin
        tk = 1'b1; dly = 1'b1; tgt = rs1_i;
      end
      OP_ESC: begin
        unique case (sub)
          ESC_CALLI: begin tk = 1'b1; dly = 1'b1; lnk = 1'b1; tgt = rs1_i; end
          ESC_LOCK:   lk_set = 1'b1;
          ESC_UNLOCK: lk_clr = 1'b1;
          ESC_NOP:    ;
          default:    ill = 1'b1;
        endcase
      end
      OP_LOOP: begin
        tk = lcc_q; dly = 1'b1; lpw = 1'b1; tgt = seq_pc + off16;
      end
      default: ;
    endcase
  end

  assign taken_o      = valid_i & tk;
  assign delay_slot_o = valid_i & tk & dly;
  assign next_pc_o    = taken_o ? tgt : seq_pc;
  assign link_we_o    = valid_i & lnk;
  assign link_data_o  = pc_i + XLEN'(8);
  assign loop_we_o    = valid_i & lpw;
  assign loop_rd_o    = instr_i[25:21];
  assign loop_sum_o   = sum_w[XLEN-1:0];
  assign illegal_o    = valid_i & ill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lcc_q      <= 1'b0;
      bus_lock_o <= 1'b0;
    end else if (valid_i) begin
      if (lpw) lcc_q <= lcc_next;
      if (lk_set) bus_lock_o <= 1'b1;
      else if (lk_clr) bus_lock_o <= 1'b0;
    end
  end

  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_we_o |=> $stable(lcc_q));
  a_r8_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op == OP_ESC && sub == ESC_LOCK) |=> bus_lock_o);
  a_r8_lock_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op == OP_ESC && sub == ESC_UNLOCK) |=> !bus_lock_o);
  a_r9_illegal_inert: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!taken_o && next_pc_o == pc_i + XLEN'(4)) ##1 $stable(bus_lock_o));
  a_r2_plain_cond_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (op == 6'h1C || op == 6'h1E)) |-> !delay_slot_o);
  a_r3_compare_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && op[5:2] == 4'h5) |-> !delay_slot_o);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |-> (!taken_o && !link_we_o && !loop_we_o && !illegal_o));
  a_r11_slot_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    delay_slot_o |-> taken_o);
endmodule

// File: tb/xfer_resolve_tb.sv
module xfer_resolve_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic valid_i = 1'b0, cc_i = 1'b0;
  logic [31:0] instr_i = '0, pc_i = '0, rs1_i = '0, rs2_i = '0;
  logic [31:0] next_pc_o, link_data_o, loop_sum_o;
  logic taken_o, delay_slot_o, link_we_o, loop_we_o, bus_lock_o, illegal_o;
  logic [4:0] loop_rd_o;

  always #2 clk = ~clk;

  xfer_resolve dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .cc_i(cc_i), .next_pc_o(next_pc_o),
    .taken_o(taken_o), .delay_slot_o(delay_slot_o), .link_we_o(link_we_o),
    .link_data_o(link_data_o), .loop_we_o(loop_we_o), .loop_rd_o(loop_rd_o),
    .loop_sum_o(loop_sum_o), .bus_lock_o(bus_lock_o), .illegal_o(illegal_o));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_lcc = 0, m_lock = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic v, input logic [31:0] ins);
    logic [5:0] op = ins[31:26];
    if (!v) return "R11";
    if (op == 6'h1A || op == 6'h1B) return "R1";
    if (op >= 6'h1C && op <= 6'h1F) return "R2";
    if (op >= 6'h14 && op <= 6'h17) return "R3";
    if (op == 6'h10) return "R4";
    if (op == 6'h2D) return "R6 R7";
    if (op == 6'h13) begin
      if (ins[4:0] == 5'd2) return "R5";
      if (ins[4:0] == 5'd1 || ins[4:0] == 5'd7 || ins[4:0] == 5'd4) return "R8";
      return "R9";
    end
    return "R11";
  endfunction

  task automatic run(input logic v, input logic [31:0] ins, pc, a, b, input logic c, input string tag_in);
    logic [5:0] op;
    logic [31:0] e_tgt, e_next, soff, loff, cmpv, s;
    logic e_tk, e_dly, e_lnk, e_lpw, e_ill, n_lcc;
    string tag;
    @(negedge clk);
    valid_i = v; instr_i = ins; pc_i = pc; rs1_i = a; rs2_i = b; cc_i = c;
    #1;
    tag = (tag_in == "") ? tag_of(v, ins) : tag_in;
    op = ins[31:26];
    soff = {{6{ins[25]}}, ins[25:0]} << 2;
    loff = {{16{ins[20]}}, ins[20:16], ins[10:0]} << 2;
    e_tk = 0; e_dly = 0; e_lnk = 0; e_lpw = 0; e_ill = 0; e_tgt = 32'h0;
    if (v) begin
      case (op)
        6'h1A, 6'h1B: begin e_tk = 1; e_dly = 1; e_tgt = pc + 4 + soff; e_lnk = (op == 6'h1B); end
        6'h1C: begin e_tk = c;  e_tgt = pc + 4 + soff; end
        6'h1D: begin e_tk = c;  e_dly = 1; e_tgt = pc + 4 + soff; end
        6'h1E: begin e_tk = !c; e_tgt = pc + 4 + soff; end
        6'h1F: begin e_tk = !c; e_dly = 1; e_tgt = pc + 4 + soff; end
        6'h14, 6'h15, 6'h16, 6'h17: begin
          cmpv = (op == 6'h15 || op == 6'h17) ? {27'd0, ins[15:11]} : a;
          e_tk = (op <= 6'h15) ? (cmpv != b) : (cmpv == b);
          e_tgt = pc + 4 + loff;
        end
        6'h10: begin e_tk = 1; e_dly = 1; e_tgt = a; end
        6'h13: begin
          if (ins[4:0] == 5'd2) begin e_tk = 1; e_dly = 1; e_lnk = 1; e_tgt = a; end
          else if (!(ins[4:0] == 5'd1 || ins[4:0] == 5'd7 || ins[4:0] == 5'd4)) e_ill = 1;
        end
        6'h2D: begin e_tk = m_lcc; e_dly = 1; e_lpw = 1; e_tgt = pc + 4 + loff; end
        default: ;
      endcase
    end
    e_next = e_tk ? e_tgt : pc + 4;
    chk(tag, "next_pc", next_pc_o, e_next);
    chk(tag, "taken", {31'd0, taken_o}, {31'd0, e_tk});
    chk(tag, "delay_slot", {31'd0, delay_slot_o}, {31'd0, e_tk & e_dly});
    chk(tag, "link_we", {31'd0, link_we_o}, {31'd0, e_lnk});
    if (e_lnk) chk(tag, "link_data", link_data_o, pc + 8);
    chk(tag, "loop_we", {31'd0, loop_we_o}, {31'd0, e_lpw});
    if (e_lpw) begin
      chk(tag, "loop_sum", loop_sum_o, a + b);
      chk(tag, "loop_rd", {27'd0, loop_rd_o}, {27'd0, ins[25:21]});
    end
    chk(tag, "illegal", {31'd0, illegal_o}, {31'd0, e_ill});
    chk("R8", "bus_lock", {31'd0, bus_lock_o}, {31'd0, m_lock});
    if (v && op == 6'h2D) begin
      s = a + b;
      if ($signed(a) < 0) n_lcc = ($signed(s) >= 0);
      else n_lcc = (({32'd0, a} + {32'd0, b}) > 64'hFFFF_FFFF);
      m_lcc = n_lcc;
    end
    if (v && op == 6'h13 && ins[4:0] == 5'd1) m_lock = 1;
    if (v && op == 6'h13 && ins[4:0] == 5'd7) m_lock = 0;
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] s2, input logic [4:0] d,
                                     input logic [4:0] s1, input logic [10:0] lo);
    return {op, s2, d, s1, lo};
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [31:0] VALS [7] = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                                       32'h8000_0000, 32'd5, 32'hFFFF_FFFB};

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R10: reset state, first loop instruction falls through
    run(1'b1, mk(6'h2D, 5'd9, 5'h1F, 5'd3, 11'h7FF), 32'h1000, 32'hFFFF_FFFF, 32'd3, 1'b0, "R10");
    // R11: idle cycles leave state alone
    run(1'b0, mk(6'h1A, 5'd0, 5'd0, 5'd0, 11'd4), 32'h2000, 32'd0, 32'd0, 1'b1, "R11");
    run(1'b0, mk(6'h13, 5'd0, 5'd0, 5'd0, 11'd1), 32'h2004, 32'd0, 32'd0, 1'b1, "R11");
    run(1'b0, mk(6'h2D, 5'd1, 5'd0, 5'd0, 11'd4), 32'h2008, 32'hFFFF_FFFF, 32'd0, 1'b0, "R11");
    // sweep all opcodes, both CC values, several operand and offset patterns
    for (int op = 0; op < 64; op++)
      for (int c = 0; c < 2; c++)
        for (int p = 0; p < 4; p++) begin
          logic [31:0] ins, pc, a, b;
          ins = {op[5:0], 26'h0};
          case (p)
            0: begin ins[25:0] = 26'h000_0010; pc = 32'h0000_4000; a = 32'd7; b = 32'd7; end
            1: begin ins[25:0] = 26'h3FF_FFF0; pc = 32'h8000_0100; a = 32'd3; b = 32'd9; end
            2: begin ins[25:0] = {5'd4, 5'h10, 5'd9, 11'h005}; pc = 32'h0001_0000; a = 32'h1234; b = 32'd9; end
            default: begin ins[25:0] = {5'd1, 5'h0F, 5'd2, 11'h7FE}; pc = 32'hF040_0000; a = 32'hFFFF_FFF0; b = 32'd2; end
          endcase
          if (op == 6'h13) ins[4:0] = 5'd4;
          run(1'b1, ins, pc, a, b, c[0], "");
        end
    // R5 R8 R9: every escape sub-op, lock set and clear ordering
    for (int s = 0; s < 32; s++)
      run(1'b1, mk(6'h13, 5'd0, 5'd0, 5'd6, {6'd0, s[4:0]}), 32'h3000 + s * 4, 32'h0040_0800, 32'd0, 1'b0, "");
    run(1'b1, mk(6'h13, 5'd0, 5'd0, 5'd0, 11'd1), 32'h3100, 32'd0, 32'd0, 1'b0, "R8");
    run(1'b1, mk(6'h13, 5'd0, 5'd0, 5'd0, 11'd4), 32'h3104, 32'd0, 32'd0, 1'b0, "R8");
    run(1'b1, mk(6'h13, 5'd0, 5'd0, 5'd0, 11'd9), 32'h3108, 32'd0, 32'd0, 1'b0, "R9");
    run(1'b1, mk(6'h13, 5'd0, 5'd0, 5'd0, 11'd7), 32'h310C, 32'd0, 32'd0, 1'b0, "R8");
    run(1'b1, mk(6'h13, 5'd0, 5'd0, 5'd0, 11'd3), 32'h3110, 32'd0, 32'd0, 1'b0, "R9");
    // R7: flag rule over corner operand pairs, probed by a second loop instruction
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++) begin
        run(1'b1, mk(6'h2D, 5'd18, 5'd0, 5'd17, 11'd8), 32'h5000, VALS[i], VALS[j], 1'b0, "R7");
        run(1'b1, mk(6'h2D, 5'd18, 5'h1F, 5'd17, 11'h7F8), 32'h5004, 32'd0, 32'd0, 1'b0, "R6");
      end
    // R6: countdown idiom (add -1 each pass)
    run(1'b1, mk(6'h2D, 5'd18, 5'd0, 5'd17, 11'd2), 32'h6000, 32'hFFFF_FFFF, 32'd2, 1'b0, "R6");
    run(1'b1, mk(6'h2D, 5'd18, 5'd0, 5'd17, 11'd2), 32'h6010, 32'hFFFF_FFFF, 32'd1, 1'b0, "R6");
    run(1'b1, mk(6'h2D, 5'd18, 5'd0, 5'd17, 11'd2), 32'h6010, 32'hFFFF_FFFF, 32'd0, 1'b0, "R6");
    run(1'b1, mk(6'h2D, 5'd18, 5'd0, 5'd17, 11'd2), 32'h6010, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R6");
    run(1'b1, mk(6'h2D, 5'd18, 5'd0, 5'd17, 11'd2), 32'h6010, 32'd0, 32'd0, 1'b0, "R6");
    // R3: constant compare against all 5-bit values
    for (int k = 0; k < 32; k++) begin
      run(1'b1, mk(6'h17, 5'd4, 5'd0, k[4:0], 11'd3), 32'h7000, 32'd0, 32'd13, 1'b0, "R3");
      run(1'b1, mk(6'h15, 5'd4, 5'h1F, k[4:0], 11'd3), 32'h7000, 32'd0, 32'd13, 1'b0, "R3");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule